// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Control Register

This block moves one byte at a time over a four-wire synchronous serial link. A bus-side register port gives access to a control register, a status register and a data register. Software uses the control register to pick the role (clock master or clock follower), the clock idle level, the capture edge and the master bit rate. In master role the block makes the serial clock from the system clock and starts a byte when software writes the data register. In follower role it tracks an external serial clock while its select input is low.

At the end of each byte the block raises an end-of-byte flag. It raises an overrun flag if a byte completes while the previous one is still unacknowledged. It raises a fault flag if its select input goes low while it is master. The three flags share one interrupt output, and the interrupt-enable bit masks it. A fault also drops the block off the pins and out of master role, so two masters never drive the link at the same time.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1) and the data register (address 2) read 0x00, `irq` is 0, and `sck_oe`, `mosi_oe` and `miso_oe` are 0.
- R2: The control register reads back as written. Its bits from 7 down to 0 are: interrupt enable, port enable, half-stage bypass, master, CPOL, CPHA, rate[1:0]. With port enable=1 and master=1, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0.
- R3: In master role each SCK half period lasts D/2 system clocks, where D comes from the code {bypass, rate[1:0]}: 100→4, 000→8, 001→16, 110→32, 010→64, 011→128, and 101 or 111→128.
- R4: In master role a write to address 2 sends that byte MSB first on `mosi_out` and collects 8 bits from `miso_in`, MSB first. At the end, status bit 7 (end of byte) is set and address 2 returns the received byte.
- R5: In master role SCK idles at the CPOL level before and after a byte. With CPHA=0, data is captured on SCK edges 1, 3, 5 and so on. With CPHA=1, it is captured on edges 2, 4, 6 and so on.
- R6: In follower role (port enable=1, master=0, `ss_n`=0) the block captures `mosi_in` on the capture edges of `sck_in`, with the same CPHA rule, and drives the byte last written to address 2 on `miso_out`, MSB first. `miso_oe` is 1 and the rate bits have no effect.
- R7: If `ss_n` is low while port enable=1 and master=1, the block clears control bits 6 and 4 and sets status bit 6 (fault) at the next clock.
- R8: If a byte completes while status bit 7 is still set, status bit 5 (overrun) is set and address 2 keeps the earlier byte.
- R9: `irq` is 1 exactly when control bit 7 is 1 and at least one of status bits 7, 6 and 5 is set.
- R10: Writing 1 to a status bit at address 1 clears that bit, and writing 0 leaves it as it is.
- R11: In master role a write to address 2 while a byte is in flight is ignored, and the byte in flight goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Combined interrupt |
| sck_in | input | 1 | Serial clock from the link (follower role) |
| sck_out | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for the serial clock |
| mosi_in | input | 1 | Follower data input |
| mosi_out | output | 1 | Master data output |
| mosi_oe | output | 1 | Output enable for master data |
| miso_in | input | 1 | Master data input |
| miso_out | output | 1 | Follower data output |
| miso_oe | output | 1 | Output enable for follower data |
| ss_n | input | 1 | Active-low select; fault source in master role |

## Verification
The assertions check, on every cycle, these rules: the fault response clears the port-enable and master bits and sets the fault flag; an overrun leaves the data register untouched; the interrupt rises with the end-of-byte flag when the interrupt is enabled; the clock parks at its CPOL level when a master byte ends; two rate ticks never come back to back; and each capture edge takes the serial input. Only the bench scenarios can show the end-to-end behaviour. That covers the exact half period for all eight rate codes, MSB-first order in both directions under each CPOL/CPHA pairing, follower transfers driven from an external clock, and a data write in the middle of a byte being ignored.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int SPI_DW  = 8;
  localparam int MAX_DIV = 128;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       intr_en;
    logic       port_en;
    logic       half_off;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // System clocks per full SCK period for a {bypass, rate} code.
  function automatic int unsigned sck_div(input logic [2:0] code);
    case (code)
      3'b100:  return 4;
      3'b000:  return 8;
      3'b001:  return 16;
      3'b110:  return 32;
      3'b010:  return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_ctl_pkg::*;
#(
  parameter int MAXD = MAX_DIV
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  localparam int CW = $clog2(MAXD / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;

  assign half_m1 = CW'(sck_div(code) / 2 - 1);
  assign tick    = run && (cnt_q >= half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_p
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-1:0], din};
  end

  assign edge_p = sr_q[STAGES] ^ sr_q[STAGES-1];
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          abort,
  input  logic          edge_p,
  input  logic          cpha,
  input  logic          sin,
  output logic          sout,
  output logic          done,
  output logic [DW-1:0] rx,
  output logic          active
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0] cnt_q;
  logic [DW-1:0] tx_q, rx_q;
  logic          done_q;
  logic          is_sample, is_shift, last_edge;

  assign is_sample = (cnt_q[0] == cpha);
  assign is_shift  = !is_sample && (cnt_q != '0) && (cnt_q != LAST);
  assign last_edge = edge_p && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_edge && !abort;
      if (abort)          cnt_q <= '0;
      else if (last_edge) cnt_q <= '0;
      else if (edge_p)    cnt_q <= cnt_q + 1'b1;
      if (load)                        tx_q <= load_val;
      else if (edge_p && is_shift)     tx_q <= {tx_q[DW-2:0], 1'b0};
      if (edge_p && is_sample && !abort) rx_q <= {rx_q[DW-2:0], sin};
    end
  end

  assign sout   = tx_q[DW-1];
  assign done   = done_q;
  assign rx     = rx_q;
  assign active = (cnt_q != '0);

  // R4
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(edge_p));
  // R5
  sample_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && is_sample && !abort) |=> rx_q[0] == $past(sin));
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       mosi_in,
  output logic       mosi_out,
  output logic       mosi_oe,
  input  logic       miso_in,
  output logic       miso_out,
  output logic       miso_oe,
  input  logic       ss_n
);
  ctrl_t             ctrl_q;
  logic              eot_q, modf_q, ovr_q;
  logic [SPI_DW-1:0] data_q;
  logic              busy_q, sck_tgl_q;

  logic master_on, slave_sel, fault;
  logic wr_ctrl, wr_stat, wr_data;
  logic start, slave_load;
  logic tick, s_edge;
  logic eng_edge, eng_abort, eng_sin, eng_sout, eng_done, eng_active;
  logic [SPI_DW-1:0] eng_rx;

  assign master_on = ctrl_q.port_en && ctrl_q.master;
  assign slave_sel = ctrl_q.port_en && !ctrl_q.master && !ss_n;
  assign fault     = master_on && !ss_n;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);

  assign start      = wr_data && master_on && !busy_q && !fault;
  assign slave_load = wr_data && !master_on && !eng_active;

  spi_baud_gen #(.MAXD(MAX_DIV)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .code({ctrl_q.half_off, ctrl_q.rate}), .tick(tick)
  );

  spi_pin_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(sck_in), .edge_p(s_edge)
  );

  assign eng_edge  = master_on ? tick : (slave_sel && s_edge);
  assign eng_abort = fault || (master_on ? (!busy_q && !start) : !slave_sel);
  assign eng_sin   = master_on ? miso_in : mosi_in;

  spi_shift_eng #(.DW(SPI_DW)) eng_i (
    .clk(clk), .rst_n(rst_n), .load(start || slave_load),
    .load_val(bus_wdata), .abort(eng_abort), .edge_p(eng_edge),
    .cpha(ctrl_q.cpha), .sin(eng_sin), .sout(eng_sout),
    .done(eng_done), .rx(eng_rx), .active(eng_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      eot_q     <= 1'b0;
      modf_q    <= 1'b0;
      ovr_q     <= 1'b0;
      data_q    <= '0;
      busy_q    <= 1'b0;
      sck_tgl_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
      if (fault) begin
        ctrl_q.port_en <= 1'b0;
        ctrl_q.master  <= 1'b0;
      end

      if (fault || eng_done) busy_q <= 1'b0;
      else if (start)        busy_q <= 1'b1;

      if (!busy_q)   sck_tgl_q <= ctrl_q.cpol;
      else if (tick) sck_tgl_q <= ~sck_tgl_q;

      if (wr_stat && bus_wdata[7]) eot_q  <= 1'b0;
      if (wr_stat && bus_wdata[6]) modf_q <= 1'b0;
      if (wr_stat && bus_wdata[5]) ovr_q  <= 1'b0;
      if (fault) modf_q <= 1'b1;
      if (eng_done) begin
        eot_q <= 1'b1;
        if (eot_q) ovr_q  <= 1'b1;
        else       data_q <= eng_rx;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {eot_q, modf_q, ovr_q, 5'b0};
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq      = ctrl_q.intr_en && (eot_q || modf_q || ovr_q);
  assign sck_oe   = master_on;
  assign sck_out  = busy_q ? sck_tgl_q : ctrl_q.cpol;
  assign mosi_oe  = master_on;
  assign mosi_out = eng_sout;
  assign miso_oe  = slave_sel;
  assign miso_out = eng_sout;

  // R7
  modf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl_q.port_en && !ctrl_q.master && modf_q));
  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eot_q) |=> (ovr_q && $stable(data_q)));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eot_q) && ctrl_q.intr_en) |-> irq);
  // R5
  sck_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_on && eng_done) |-> (sck_out == ctrl_q.cpol));
endmodule

// File: tb/spi_ctl_top_tb_top.sv
module spi_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, ss_n = 1'b1;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  spi_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_div(input logic [2:0] c);
    if (c == 3'b100) return 4;
    if (c == 3'b110) return 32;
    if (c[2])        return 128;
    case (c[1:0])
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 128;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb,
                             input bit cpol, input bit cpha, input logic [2:0] code,
                             input bit poke, output logic [7:0] seen);
    int idx = 0, samp = 0, t = 0;
    logic prev;
    wr(2'd0, {1'b0, 1'b1, code[2], 1'b1, cpol, cpha, code[1:0]});
    miso_in = sb[7];
    chk(sck_out == cpol, "R5 idle before", sck_out, cpol);
    wr(2'd2, tx);
    prev = sck_out;
    while (idx < 16) begin
      @(negedge clk);
      bus_wr = 1'b0;
      t++;
      if (sck_out != prev) begin
        prev = sck_out;
        if (idx >= 1) chk(t == exp_div(code) / 2, "R3 half period", t, exp_div(code) / 2);
        if ((idx % 2) == int'(cpha)) begin
          seen[7 - samp] = mosi_out;
          samp++;
          if (samp < 8) miso_in = sb[7 - samp];
        end
        idx++;
        t = 0;
        if (poke && idx == 3) begin
          bus_addr = 2'd2; bus_wdata = ~tx; bus_wr = 1'b1;
        end
      end
    end
    repeat (3) @(negedge clk);
    chk(sck_out == cpol, "R5 idle after", sck_out, cpol);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] mtx,
                            input bit cpol, input bit cpha, output logic [7:0] got);
    int k = 0;
    wr(2'd0, {1'b0, 1'b1, 1'b1, 1'b0, cpol, cpha, 2'b11});
    sck_in = cpol;
    mosi_in = mtx[7];
    repeat (4) @(negedge clk);
    wr(2'd2, tx);
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(miso_oe && !sck_oe && !mosi_oe, "R6 follower enables",
        {miso_oe, sck_oe, mosi_oe}, 3'b100);
    for (int idx = 0; idx < 16; idx++) begin
      repeat (8) @(negedge clk);
      if ((idx % 2) == int'(cpha)) begin
        got[7 - k] = miso_out;
        k++;
      end
      sck_in = ~sck_in;
      if (!cpha && (idx % 2) == 1 && idx < 15) mosi_in = mtx[7 - (idx + 1) / 2];
      if (cpha && (idx % 2) == 0) mosi_in = mtx[7 - idx / 2];
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, seen, s1;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 8'h00);
    rd(2'd2, v); chk(v == 8'h00, "R1 data", v, 8'h00);
    chk({irq, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 outputs",
        {irq, sck_oe, mosi_oe, miso_oe}, 0);

    // R2 readback and pin roles
    wr(2'd0, 8'h2D); rd(2'd0, v); chk(v == 8'h2D, "R2 readback", v, 8'h2D);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R2 disabled oe", {sck_oe, mosi_oe, miso_oe}, 0);
    wr(2'd0, 8'h5C); rd(2'd0, v); chk(v == 8'h5C, "R2 readback master", v, 8'h5C);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b110, "R2 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    chk(sck_out == 1'b1, "R5 idle high", sck_out, 1);

    // R3/R4: every rate code, directed
    for (int c = 0; c < 8; c++) begin
      logic [7:0] tx, sb;
      tx = 8'h81 ^ 8'(c * 37); sb = 8'h5A ^ 8'(c * 19);
      master_xfer(tx, sb, c[0], c[1], 3'(c), 1'b0, seen);
      chk(seen == tx, "R4 mosi order", seen, tx);
      rd(2'd1, v); chk(v == 8'h80, "R4 end flag", v, 8'h80);
      rd(2'd2, v); chk(v == sb, "R4 rx byte", v, sb);
      wr(2'd1, 8'hE0); rd(2'd1, v); chk(v == 8'h00, "R10 clear", v, 8'h00);
    end

    // R4/R5 random transfers
    for (int i = 0; i < 6; i++) begin
      logic [7:0] tx, sb;
      logic [2:0] code;
      tx = 8'($urandom); sb = 8'($urandom); code = 3'($urandom);
      master_xfer(tx, sb, 1'($urandom), 1'($urandom), code, 1'b0, seen);
      chk(seen == tx, "R4 random mosi", seen, tx);
      rd(2'd2, v); chk(v == sb, "R4 random rx", v, sb);
      wr(2'd1, 8'hE0);
    end

    // R11 data write mid-byte ignored
    master_xfer(8'hC3, 8'h3C, 1'b0, 1'b0, 3'b100, 1'b1, seen);
    chk(seen == 8'hC3, "R11 mid-byte write", seen, 8'hC3);
    wr(2'd1, 8'hE0);

    // R8 overrun keeps earlier byte
    s1 = 8'hA7;
    master_xfer(8'h11, s1, 1'b1, 1'b0, 3'b000, 1'b0, seen);
    master_xfer(8'h22, 8'h6E, 1'b1, 1'b0, 3'b000, 1'b0, seen);
    rd(2'd1, v); chk(v == 8'hA0, "R8 overrun flag", v, 8'hA0);
    rd(2'd2, v); chk(v == s1, "R8 data kept", v, s1);

    // R9 interrupt masking
    chk(irq == 1'b0, "R9 masked", irq, 0);
    wr(2'd0, 8'hD0); chk(irq == 1'b1, "R9 enabled", irq, 1);
    wr(2'd1, 8'h20); rd(2'd1, v); chk(v == 8'h80, "R10 partial clear", v, 8'h80);
    wr(2'd1, 8'h80); chk(irq == 1'b0, "R9 all clear", irq, 0);

    // R7 mode fault
    @(negedge clk); ss_n = 1'b0;
    @(negedge clk); ss_n = 1'b1;
    rd(2'd0, v); chk(v == 8'h80, "R7 ctrl bits dropped", v, 8'h80);
    rd(2'd1, v); chk(v == 8'h40, "R7 fault flag", v, 8'h40);
    chk(irq == 1'b1, "R9 fault irq", irq, 1);
    chk({sck_oe, mosi_oe} == 2'b00, "R7 pins released", {sck_oe, mosi_oe}, 0);
    wr(2'd1, 8'hE0);

    // R6 follower transfers
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tx, mtx;
      tx = 8'($urandom); mtx = 8'($urandom);
      slave_xfer(tx, mtx, m[1], m[0], seen);
      chk(seen == tx, "R6 miso order", seen, tx);
      rd(2'd1, v); chk(v == 8'h80, "R6 end flag", v, 8'h80);
      rd(2'd2, v); chk(v == mtx, "R6 rx byte", v, mtx);
      ss_n = 1'b1;
      wr(2'd1, 8'hE0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule